// File: doc/BRIEF.md
# Power-On Strap Latch and Shared Clock Pin Controller

This block sits between two shared package pins and the clock sources of a peripheral clock generator. While power-on reset is held, both pins are inputs. One of them carries a three-level spread-spectrum strap, which an analog front end turns into two comparator bits: one for above the high threshold and one for below the low threshold. The other pin carries an ordinary two-level crystal-select strap. The block samples both straps at the clock edge that follows reset release. It then holds them until reset is asserted again.

After the capture the block decodes the straps. The spread-spectrum mode can be off, ±0.5 % centre spread or ±0.75 % centre spread. The crystal select picks between the 24.576 MHz crystal and the 14.31818 MHz crystal. One clock later the block enables both pin drivers. The spread-spectrum pin then carries the 24.576 MHz clock. The crystal-select pin carries either the synthesized 27 MHz clock or, with the 14.31818 MHz crystal, the crystal clock passed straight through. A flag tells the PLL logic whether the 27 MHz path is modulated. The clocks enter as ordinary signals, and the analog circuits are modelled elsewhere.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rst` is high, both output enables and both pin outputs are 0, `ss_mode` is 2'b00 and `xtal_14m` and `ss_active` are 0.
- R2: The straps are sampled at the first rising edge of `clk` at which `rst` is low, and the decoded values appear right after that edge.
- R3: The spread strap decodes as follows: `ss_above`=1 with `ss_below`=0 gives `ss_mode`=2'b10 (±0.75 %). `ss_below`=1 with `ss_above`=0 gives 2'b01 (±0.5 %). Both 0 (floating mid level) gives 2'b00 (off).
- R4: The illegal code `ss_above`=1 with `ss_below`=1 resolves to the mid level, so `ss_mode`=2'b00.
- R5: `xsel_in`=0 at capture gives `xtal_14m`=0 (24.576 MHz crystal), and `xsel_in`=1 gives `xtal_14m`=1 (14.31818 MHz crystal).
- R6: `pin_a_oe` and `pin_b_oe` stay 0 through reset and through the capture edge. Both rise together at the second rising edge after release.
- R7: `pin_a_out` equals `clk_24m` while `pin_a_oe` is 1, and is 0 otherwise.
- R8: While `pin_b_oe` is 1, `pin_b_out` equals `clk_27m` when `xtal_14m`=0 and `clk_xtal` when `xtal_14m`=1. While `pin_b_oe` is 0, `pin_b_out` is 0.
- R9: After capture, changes on `ss_above`, `ss_below` and `xsel_in` have no effect on `ss_mode`, `xtal_14m` or `ss_active` until reset is asserted again.
- R10: `ss_active` is 1 exactly when `ss_mode` is not 2'b00 and `xtal_14m` is 0. It is 0 in pass-through mode.
- R11: A new assertion and release of `rst` captures the straps afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the capture logic |
| rst | input | 1 | Active-high power-on reset |
| ss_above | input | 1 | Spread strap comparator: pin above high threshold |
| ss_below | input | 1 | Spread strap comparator: pin below low threshold |
| xsel_in | input | 1 | Crystal-select strap level |
| clk_24m | input | 1 | 24.576 MHz clock source |
| clk_27m | input | 1 | Synthesized 27 MHz clock source |
| clk_xtal | input | 1 | Crystal oscillator clock for pass-through |
| pin_a_oe | output | 1 | Driver enable of the spread strap pin |
| pin_a_out | output | 1 | Clock driven on the spread strap pin |
| pin_b_oe | output | 1 | Driver enable of the crystal-select pin |
| pin_b_out | output | 1 | Clock driven on the crystal-select pin |
| ss_mode | output | 2 | 00 off, 01 ±0.5 %, 10 ±0.75 % |
| xtal_14m | output | 1 | 1 when the 14.31818 MHz crystal is selected |
| ss_active | output | 1 | 27 MHz path is spread-modulated |

## Verification
The assertions assume that the strap inputs are settled at the capture edge. They also assume that reset lasts at least one clock, so the capture register and the enable counter are seen cleared before release. The bench changes straps and clock levels only on falling edges, and it holds reset for several cycles in every scenario. After capture it keeps toggling the strap inputs at random, so it tests R9 without disturbing the capture edge itself.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
   typedef enum logic [1:0] {
      SS_OFF  = 2'b00,
      SS_HALF = 2'b01,
      SS_WIDE = 2'b10
   } ss_mode_e;
endpackage

// File: rtl/tri_level_resolve.sv
module tri_level_resolve
   import strap_latch_pkg::*;
#(
   parameter bit BOTH_IS_MID = 1'b1
) (
   input  logic     above,
   input  logic     below,
   output ss_mode_e mode
);
   ss_mode_e conflict_mode;

   generate
      if (BOTH_IS_MID) begin : g_conflict_mid
         assign conflict_mode = SS_OFF;
      end else begin : g_conflict_high
         assign conflict_mode = SS_WIDE;
      end
   endgenerate

   always_comb begin
      unique case ({above, below})
         2'b10:   mode = SS_WIDE;
         2'b01:   mode = SS_HALF;
         2'b11:   mode = conflict_mode;
         default: mode = SS_OFF;
      endcase
   end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_latch_pkg::*;
#(
   parameter int OE_DELAY = 1
) (
   input  logic     clk,
   input  logic     rst,
   input  ss_mode_e ss_raw,
   input  logic     xsel_raw,
   output ss_mode_e ss_q,
   output logic     xsel_q,
   output logic     cap_done,
   output logic     drive_en
);
   localparam int CW = (OE_DELAY < 2) ? 1 : $clog2(OE_DELAY + 1);
   localparam logic [CW-1:0] DLY_END = CW'(OE_DELAY);

   initial begin
      if (OE_DELAY < 1) $error("OE_DELAY must be at least 1");
   end

   logic [CW-1:0] dly_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         ss_q     <= SS_OFF;
         xsel_q   <= 1'b0;
         cap_done <= 1'b0;
         dly_cnt  <= '0;
      end else if (!cap_done) begin
         ss_q     <= ss_raw;
         xsel_q   <= xsel_raw;
         cap_done <= 1'b1;
      end else if (dly_cnt != DLY_END) begin
         dly_cnt  <= dly_cnt + 1'b1;
      end
   end

   assign drive_en = cap_done && (dly_cnt == DLY_END);

   // R6: no driver enable on the first edge after release
   p_no_drive_at_release_r6: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !drive_en);

   // R6: enable only ever rises after capture has completed
   p_drive_after_cap_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(drive_en) |-> $past(cap_done));

   // R9: captured straps frozen once latched
   p_strap_hold_r9: assert property (@(posedge clk) disable iff (rst)
      $past(cap_done) |-> ($stable(ss_q) && $stable(xsel_q)));
endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
   parameter bit HAS_ALT = 1'b1
) (
   input  logic en,
   input  logic sel_alt,
   input  logic src_main,
   input  logic src_alt,
   output logic pin_out
);
   logic picked;

   generate
      if (HAS_ALT) begin : g_two_src
         assign picked = sel_alt ? src_alt : src_main;
      end else begin : g_one_src
         logic unused_alt;
         assign unused_alt = sel_alt ^ src_alt;
         assign picked     = src_main;
      end
   endgenerate

   assign pin_out = en & picked;
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
   import strap_latch_pkg::*;
#(
   parameter int OE_DELAY    = 1,
   parameter bit BOTH_IS_MID = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ss_above,
   input  logic       ss_below,
   input  logic       xsel_in,
   input  logic       clk_24m,
   input  logic       clk_27m,
   input  logic       clk_xtal,
   output logic       pin_a_oe,
   output logic       pin_a_out,
   output logic       pin_b_oe,
   output logic       pin_b_out,
   output logic [1:0] ss_mode,
   output logic       xtal_14m,
   output logic       ss_active
);
   ss_mode_e raw_mode;
   ss_mode_e held_mode;
   logic     cap_done;
   logic     drive_en;

   tri_level_resolve #(.BOTH_IS_MID(BOTH_IS_MID)) u_resolve (
      .above (ss_above),
      .below (ss_below),
      .mode  (raw_mode)
   );

   strap_capture #(.OE_DELAY(OE_DELAY)) u_capture (
      .clk      (clk),
      .rst      (rst),
      .ss_raw   (raw_mode),
      .xsel_raw (xsel_in),
      .ss_q     (held_mode),
      .xsel_q   (xtal_14m),
      .cap_done (cap_done),
      .drive_en (drive_en)
   );

   pin_drive #(.HAS_ALT(1'b0)) u_pin_a (
      .en       (drive_en),
      .sel_alt  (1'b0),
      .src_main (clk_24m),
      .src_alt  (1'b0),
      .pin_out  (pin_a_out)
   );

   pin_drive #(.HAS_ALT(1'b1)) u_pin_b (
      .en       (drive_en),
      .sel_alt  (xtal_14m),
      .src_main (clk_27m),
      .src_alt  (clk_xtal),
      .pin_out  (pin_b_out)
   );

   assign pin_a_oe  = drive_en;
   assign pin_b_oe  = drive_en;
   assign ss_mode   = held_mode;
   assign ss_active = (held_mode != SS_OFF) && !xtal_14m;

   // R10: modulation flag never set in pass-through mode
   p_flag_not_passthru_r10: assert property (@(posedge clk) disable iff (rst)
      ss_active |-> (!xtal_14m && cap_done));

   // R8: crystal-select pin silent while its driver is off
   p_pin_b_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !pin_b_oe |-> !pin_b_out);

   // R7: spread pin silent while its driver is off
   p_pin_a_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !pin_a_oe |-> !pin_a_out);
endmodule

// File: tb/strap_latch_ctrl_tb.sv
module strap_latch_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ss_above = 1'b0, ss_below = 1'b0, xsel_in = 1'b0;
   logic       clk_24m = 1'b0, clk_27m = 1'b0, clk_xtal = 1'b0;
   logic       pin_a_oe, pin_a_out, pin_b_oe, pin_b_out;
   logic [1:0] ss_mode;
   logic       xtal_14m, ss_active;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference state
   bit m_cap   = 0;
   int m_edges = 0;
   int m_mode  = 0;
   bit m_x     = 0;

   always #4 clk = ~clk;

   strap_latch_ctrl u_dut (
      .clk(clk), .rst(rst), .ss_above(ss_above), .ss_below(ss_below),
      .xsel_in(xsel_in), .clk_24m(clk_24m), .clk_27m(clk_27m),
      .clk_xtal(clk_xtal), .pin_a_oe(pin_a_oe), .pin_a_out(pin_a_out),
      .pin_b_oe(pin_b_oe), .pin_b_out(pin_b_out), .ss_mode(ss_mode),
      .xtal_14m(xtal_14m), .ss_active(ss_active)
   );

   function automatic int exp_mode(bit hi, bit lo);
      if (hi && !lo) return 2;   // R3 wide
      if (lo && !hi) return 1;   // R3 half
      return 0;                  // R3 mid, R4 conflict
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cap = 0; m_edges = 0; m_mode = 0; m_x = 0;
      end else if (!m_cap) begin
         m_mode = exp_mode(ss_above, ss_below);
         m_x    = xsel_in;
         m_cap  = 1;
      end else begin
         m_edges = m_edges + 1;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit oe;
      oe = m_cap && (m_edges >= 1);
      chk("R3,R4 ss_mode", ss_mode, m_mode);
      chk("R5 xtal_14m", xtal_14m, m_x);
      chk("R10 ss_active", ss_active, (m_mode != 0) && !m_x);
      chk("R6 pin_a_oe", pin_a_oe, oe);
      chk("R6 pin_b_oe", pin_b_oe, oe);
      chk("R7 pin_a_out", pin_a_out, oe & clk_24m);
      chk("R8 pin_b_out", pin_b_out, oe & (m_x ? clk_xtal : clk_27m));
   endtask

   task automatic cycle(bit jitter_straps);
      @(negedge clk);
      clk_24m  = $urandom_range(0, 1);
      clk_27m  = $urandom_range(0, 1);
      clk_xtal = $urandom_range(0, 1);
      if (jitter_straps) begin
         ss_above = $urandom_range(0, 1);
         ss_below = $urandom_range(0, 1);
         xsel_in  = $urandom_range(0, 1);
      end
      #1;
      compare_all();
   endtask

   task automatic scenario(bit hi, bit lo, bit xs);
      rst = 1'b1;
      ss_above = hi; ss_below = lo; xsel_in = xs;
      for (int i = 0; i < 3; i++) begin
         cycle(1'b0);
         // R1: reset state at the ports
         chk("R1 oe in reset", pin_a_oe | pin_b_oe, 0);
         chk("R1 mode in reset", {ss_mode, xtal_14m, ss_active}, 0);
      end
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      // R2: straps visible right after the first edge; R11 on repeats
      chk("R2 R11 captured mode", ss_mode, exp_mode(hi, lo));
      chk("R2 R11 captured xsel", xtal_14m, xs);
      chk("R6 oe low at capture", pin_a_oe, 0);
      compare_all();
      // R9: straps wiggle after capture and must be ignored
      for (int i = 0; i < 8; i++) cycle(1'b1);
      chk("R9 mode held", ss_mode, exp_mode(hi, lo));
      chk("R9 xsel held", xtal_14m, xs);
   endtask

   initial begin
      fork
         begin
            for (int r = 0; r < 3; r++)
               for (int p = 0; p < 8; p++)
                  scenario(p[2], p[1], p[0]);
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule